// File: doc/BRIEF.md
# Twin-Phase Timer with Watchdog

This peripheral holds two down-counting timers behind a small register bus. Every period of a timer has two parts that are loaded separately. The first is a timeout phase, during which the timer's output is low. The second is a pulse phase, during which the output is high. When the pulse phase ends, the timer reloads and begins the next period, so the period length is the sum of the two loaded counts. Software starts a timer by setting its bit in a shared control register. To change a timer's counts, software clears that bit, writes the counts, and sets the bit again.

Timer 1 drives the interrupt. Each period it completes sets a pending flag, and software clears the flag by writing a one to it. Timer 0 has a second use as a watchdog. When the low byte of its timeout register holds the key value 0xFF, the upper bits of that register give a reload count. Timer 0 then counts that value down and raises a one-cycle reset request when it runs out. Software keeps the watchdog from firing by rewriting the register, which is the kick.

Top module: `twin_phase_timer`

## Requirements
- R1: The registers sit at these byte addresses: control at 0x00 (bit 0 enables timer 0, bit 1 enables timer 1, all other bits read 0), timer 1 timeout at 0x04, timer 0 timeout at 0x08, timer 1 pulse at 0x0C, timer 0 pulse at 0x10, and interrupt pending at 0x14 (bit 0). The count registers are 32 bits wide and read back what was written. Read data appears on `bus_rdata` in the cycle after the one in which `bus_re` is sampled high.
- R2: After reset, every register reads 0, and `irq_o`, `tmr_out_o` and `wdog_rst_o` are all low.
- R3: When software writes a 0-to-1 change to an enable bit, that timer loads its timeout count and starts in the timeout phase, with its output low.
- R4: A running timer holds its output low for T cycles and then high for P cycles, where T is its timeout count and P its pulse count. A count of 0 behaves as 1. After that the timer reloads and repeats, so the period is T+P, with a minimum of 2.
- R5: At the end of every timer 1 period the pending bit is set, and `irq_o` follows the pending bit as a level.
- R6: Writing 1 to bit 0 of 0x14 clears the pending bit. Writing 0 to that bit leaves it unchanged, and so does disabling timer 1.
- R7: While a timer's enable bit is 0, its output stays low and it sets no pending bit.
- R8: Timer 0 never sets the pending bit.
- R9: When the low byte of the timer 0 timeout register is 0xFF, timer 0 is in watchdog mode. Let N be bits 31:8 of that register. Once timer 0 is enabled, `wdog_rst_o` goes high for exactly one cycle, max(N,1) cycles after the enabling write. In this mode `tmr_out_o[0]` stays low.
- R10: In watchdog mode, writing the timer 0 timeout register with low byte 0xFF while timer 0 is enabled is a kick. It restarts the countdown from the newly written N. After the watchdog fires, it gives no further pulse until it is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt from the pending bit |
| tmr_out_o | output | 2 | Phase output per timer, high during the pulse phase |
| wdog_rst_o | output | 1 | One-cycle reset request from the watchdog |

## Verification
The assertions check the following on every cycle:
- a start always opens a timeout phase;
- the end of a period reloads the timeout count;
- the end of a timer 1 period sets the pending bit, and the bit holds until a clearing write;
- a disabled timer 1 and a running timer 0 cannot set the pending bit;
- the watchdog pulse never lasts longer than one cycle.

Only the bench's scenarios show that the phase lengths and the full period match the loaded counts, including the case where a count of 0 stretches to one cycle. The same holds for the exact cycle in which the watchdog fires, for a kick pushing that cycle later, and for the register map decoding each address correctly.

// File: rtl/tpt_pkg.sv
// Shared constants and types for the twin-phase timer.
// Assumes byte addressing and word-aligned register offsets.
package tpt_pkg;
    localparam int unsigned REG_CTRL  = 0;
    localparam int unsigned REG_T1_TO = 4;
    localparam int unsigned REG_T0_TO = 8;
    localparam int unsigned REG_T1_PU = 12;
    localparam int unsigned REG_T0_PU = 16;
    localparam int unsigned REG_PEND  = 20;

    localparam int unsigned KEY_W    = 8;
    localparam logic [7:0]  WDOG_KEY = 8'hFF;

    typedef enum logic {
        PH_TIMEOUT = 1'b0,
        PH_PULSE   = 1'b1
    } phase_e;
endpackage

// File: rtl/tpt_phase_timer.sv
// One two-phase down counter.
// The timeout phase runs first (output low), then the pulse phase (output high).
// The counter reloads after the pulse phase. A count of 0 acts as 1.
// Assumes start_i arrives in a cycle where en_i is still 0 (0-to-1 edge).
module tpt_phase_timer
    import tpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] tc_i,
    input  logic [CNT_W-1:0] pd_i,
    output logic             out_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    phase_e           phase_q;
    logic             last_cycle;

    assign last_cycle = (cnt_q <= ONE);

    // Load on start, then count down and switch phase on the last cycle of each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= PH_TIMEOUT;
        end else if (start_i) begin
            cnt_q   <= tc_i;
            phase_q <= PH_TIMEOUT;
        end else if (en_i) begin
            if (last_cycle) begin
                if (phase_q == PH_TIMEOUT) begin
                    cnt_q   <= pd_i;
                    phase_q <= PH_PULSE;
                end else begin
                    cnt_q   <= tc_i;
                    phase_q <= PH_TIMEOUT;
                end
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    // The output is high only while enabled and in the pulse phase.
    assign out_o  = en_i && (phase_q == PH_PULSE);

    // The period ends on the last cycle of the pulse phase.
    assign done_o = en_i && !start_i && (phase_q == PH_PULSE) && last_cycle;

    // R3: a start always opens a timeout phase with the output low.
    p_start_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (phase_q == PH_TIMEOUT) && !out_o);

    // R4: the end of a period reloads the timeout count.
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (phase_q == PH_TIMEOUT) && (cnt_q == $past(tc_i)));
endmodule

// File: rtl/tpt_watchdog.sv
// Watchdog countdown for timer 0.
// A load arms it with a count. The count runs down while enabled, and when it
// runs out fire_o is high for one cycle and the watchdog disarms.
// Assumes load_i covers both the enabling write and the kick writes.
module tpt_watchdog #(
    parameter int WD_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [WD_W-1:0] load_val_i,
    input  logic            en_i,
    output logic            fire_o
);
    localparam logic [WD_W-1:0] ONE = WD_W'(1);

    logic [WD_W-1:0] cnt_q;
    logic            armed_q;
    logic            fire_q;

    // Arm on a load, count down while enabled, and fire once at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (load_i) begin
                cnt_q   <= load_val_i;
                armed_q <= 1'b1;
            end else if (en_i && armed_q) begin
                if (cnt_q <= ONE) begin
                    fire_q  <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - ONE;
                end
            end
        end
    end

    assign fire_o = fire_q;

    // R9: the reset request lasts exactly one cycle.
    p_wdog_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

    // R10: after firing, nothing fires again without a new load.
    p_wdog_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !load_i) |=> !armed_q);
endmodule

// File: rtl/tpt_regs.sv
// Register file and bus decode for the twin-phase timer.
// Holds the control bits, the four count registers and the pending bit.
// It produces a start pulse on each 0-to-1 enable write, and read data is
// registered. Assumes single-cycle write strobes.
module tpt_regs
    import tpt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [CNT_W-1:0]     bus_wdata,
    input  logic                 bus_we,
    input  logic                 bus_re,
    output logic [CNT_W-1:0]     bus_rdata,
    input  logic                 t1_done_i,
    output logic [1:0]           ctrl_o,
    output logic [1:0]           start_o,
    output logic [1:0][CNT_W-1:0] to_o,
    output logic [1:0][CNT_W-1:0] pu_o,
    output logic                 t0_to_wr_o,
    output logic                 pend_o
);
    logic [1:0]       ctrl_q;
    logic             pend_q;
    logic             ctrl_wr;
    logic             pend_wr;
    logic [CNT_W-1:0] rd_next;
    logic [CNT_W-1:0] rdata_q;

    assign ctrl_wr    = bus_we && (bus_addr == ADDR_W'(REG_CTRL));
    assign pend_wr    = bus_we && (bus_addr == ADDR_W'(REG_PEND));
    assign t0_to_wr_o = bus_we && (bus_addr == ADDR_W'(REG_T0_TO));

    // Control bits: one independent enable per timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= bus_wdata[1:0];
        end
    end

    assign start_o = {2{ctrl_wr}} & bus_wdata[1:0] & ~ctrl_q;
    assign ctrl_o  = ctrl_q;

    // Each timer has a timeout and a pulse count register, at its own offsets.
    for (genvar i = 0; i < 2; i++) begin : g_cnt
        localparam int unsigned TO_OFF = (i == 0) ? REG_T0_TO : REG_T1_TO;
        localparam int unsigned PU_OFF = (i == 0) ? REG_T0_PU : REG_T1_PU;

        logic [CNT_W-1:0] to_r;
        logic [CNT_W-1:0] pu_r;

        // Capture writes to this timer's two count registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                to_r <= '0;
                pu_r <= '0;
            end else if (bus_we) begin
                if (bus_addr == ADDR_W'(TO_OFF)) to_r <= bus_wdata;
                if (bus_addr == ADDR_W'(PU_OFF)) pu_r <= bus_wdata;
            end
        end

        assign to_o[i] = to_r;
        assign pu_o[i] = pu_r;
    end

    // Pending bit: a finished timer 1 period sets it, a write of 1 clears it, and set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (t1_done_i) begin
            pend_q <= 1'b1;
        end else if (pend_wr && bus_wdata[0]) begin
            pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // Read mux: select the register addressed on the bus.
    always_comb begin
        rd_next = '0;
        case (bus_addr)
            ADDR_W'(REG_CTRL):  rd_next[1:0] = ctrl_q;
            ADDR_W'(REG_T1_TO): rd_next      = to_o[1];
            ADDR_W'(REG_T0_TO): rd_next      = to_o[0];
            ADDR_W'(REG_T1_PU): rd_next      = pu_o[1];
            ADDR_W'(REG_T0_PU): rd_next      = pu_o[0];
            ADDR_W'(REG_PEND):  rd_next[0]   = pend_q;
            default:            rd_next      = '0;
        endcase
    end

    // Read data register: capture the mux output on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_re) begin
            rdata_q <= rd_next;
        end
    end

    assign bus_rdata = rdata_q;

    // R5: the end of a timer 1 period always leaves the pending bit set.
    p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        t1_done_i |=> pend_q);

    // R6: only a write of 1 to the pending address clears the bit.
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !(pend_wr && bus_wdata[0])) |=> pend_q);
endmodule

// File: rtl/twin_phase_timer.sv
// Top level: register file, two two-phase timers and the timer 0 watchdog.
// Watchdog mode depends on the key byte held in the timer 0 timeout register.
// In that mode the timer 0 phase counter is idle and the watchdog runs instead.
// Assumes software clears an enable bit before it rewrites that timer's counts.
module twin_phase_timer
    import tpt_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq_o,
    output logic [1:0]        tmr_out_o,
    output logic              wdog_rst_o
);
    localparam int WD_W = CNT_W - KEY_W;

    logic [1:0]            ctrl;
    logic [1:0]            start;
    logic [1:0][CNT_W-1:0] to_cnt;
    logic [1:0][CNT_W-1:0] pu_cnt;
    logic                  t0_to_wr;
    logic                  wd_mode;
    logic [1:0]            tmr_en;
    logic [1:0]            tmr_start;
    logic [1:0]            tmr_done;
    logic                  wd_kick;
    logic                  wd_load;
    logic [WD_W-1:0]       wd_val;

    tpt_regs #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_rdata  (bus_rdata),
        .t1_done_i  (tmr_done[1]),
        .ctrl_o     (ctrl),
        .start_o    (start),
        .to_o       (to_cnt),
        .pu_o       (pu_cnt),
        .t0_to_wr_o (t0_to_wr),
        .pend_o     (irq_o)
    );

    // Watchdog mode comes from the key byte stored in the timer 0 timeout register.
    assign wd_mode = (to_cnt[0][KEY_W-1:0] == WDOG_KEY);

    // In watchdog mode the watchdog takes timer 0's enable, and the phase counter stays idle.
    assign tmr_en[0]    = ctrl[0] && !wd_mode;
    assign tmr_en[1]    = ctrl[1];
    assign tmr_start[0] = start[0] && !wd_mode;
    assign tmr_start[1] = start[1];

    for (genvar i = 0; i < 2; i++) begin : g_tmr
        tpt_phase_timer #(
            .CNT_W (CNT_W)
        ) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (tmr_start[i]),
            .en_i    (tmr_en[i]),
            .tc_i    (to_cnt[i]),
            .pd_i    (pu_cnt[i]),
            .out_o   (tmr_out_o[i]),
            .done_o  (tmr_done[i])
        );
    end

    // A kick is a keyed write to the timer 0 timeout register while timer 0 is enabled.
    assign wd_kick = t0_to_wr && ctrl[0] && (bus_wdata[KEY_W-1:0] == WDOG_KEY);
    assign wd_load = (start[0] && wd_mode) || wd_kick;
    assign wd_val  = wd_kick ? bus_wdata[CNT_W-1:KEY_W] : to_cnt[0][CNT_W-1:KEY_W];

    tpt_watchdog #(
        .WD_W (WD_W)
    ) u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (wd_load),
        .load_val_i (wd_val),
        .en_i       (ctrl[0] && wd_mode),
        .fire_o     (wdog_rst_o)
    );

    // R7: with timer 1 disabled, a clear pending bit stays clear.
    p_off_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[1] && !irq_o) |=> !irq_o);

    // R8: the end of a timer 0 period alone never raises the interrupt.
    p_t0_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_done[0] && !tmr_done[1] && !irq_o) |=> !irq_o);
endmodule

// File: tb/sim_twin_phase_timer.sv
`timescale 1ns/1ps
module sim_twin_phase_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic [1:0]  tmr_out_o;
    logic        wdog_rst_o;

    int n_chk = 0;
    int n_err = 0;
    bit timed_out = 1'b0;

    always #2.5 clk = ~clk;

    twin_phase_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_rdata  (bus_rdata),
        .irq_o      (irq_o),
        .tmr_out_o  (tmr_out_o),
        .wdog_rst_o (wdog_rst_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    // Run one timer with counts tc/pd over two periods and compare its output each cycle.
    task automatic sweep_tmr(input int idx, input int tc, input int pd);
        int te, pe, per;
        te = (tc == 0) ? 1 : tc;
        pe = (pd == 0) ? 1 : pd;
        per = te + pe;
        bus_write(5'h00, 32'h0);
        bus_write(5'h14, 32'h1);
        bus_write(idx ? 5'h04 : 5'h08, 32'(tc));
        bus_write(idx ? 5'h0C : 5'h10, 32'(pd));
        bus_write(5'h00, 32'(1 << idx));
        for (int k = 0; k < 2 * per + 1; k++) begin
            if (k == 0) chk("R3", "output at start", 32'(tmr_out_o[idx]), 32'h0);
            chk("R4", $sformatf("t%0d tc=%0d pd=%0d k=%0d", idx, tc, pd, k),
                32'(tmr_out_o[idx]), 32'((k % per) >= te));
            if (idx == 1) chk("R5", $sformatf("irq tc=%0d pd=%0d k=%0d", tc, pd, k), 32'(irq_o), 32'(k >= per));
            else          chk("R8", $sformatf("irq from timer 0 k=%0d", k), 32'(irq_o), 32'h0);
            @(negedge clk);
        end
    endtask

    task automatic run_main();
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk("R2", "irq after reset", 32'(irq_o), 32'h0);
        chk("R2", "outputs after reset", 32'(tmr_out_o), 32'h0);
        chk("R2", "wdog after reset", 32'(wdog_rst_o), 32'h0);
        for (int a = 0; a <= 20; a += 4) begin
            bus_read(5'(a), d);
            chk("R2", $sformatf("reg %0h after reset", a), d, 32'h0);
        end
        // R1: map and readback
        bus_write(5'h04, 32'hA5A5_0104);
        bus_write(5'h08, 32'h0000_1234);
        bus_write(5'h0C, 32'h8000_0001);
        bus_write(5'h10, 32'h7FFF_FFFE);
        bus_write(5'h00, 32'hFFFF_FFFE);
        bus_read(5'h04, d); chk("R1", "t1 timeout", d, 32'hA5A5_0104);
        bus_read(5'h08, d); chk("R1", "t0 timeout", d, 32'h0000_1234);
        bus_read(5'h0C, d); chk("R1", "t1 pulse", d, 32'h8000_0001);
        bus_read(5'h10, d); chk("R1", "t0 pulse", d, 32'h7FFF_FFFE);
        bus_read(5'h00, d); chk("R1", "control", d, 32'h2);
        bus_write(5'h00, 32'h0);
        bus_read(5'h00, d); chk("R1", "control cleared", d, 32'h0);
        // R4/R5: timer 1 sweep, counts 0..3 each
        for (int tc = 0; tc < 4; tc++)
            for (int pd = 0; pd < 4; pd++)
                sweep_tmr(1, tc, pd);
        bus_read(5'h14, d); chk("R1", "pending reads set", d, 32'h1);
        // R6: disabling, writing 0, then writing 1
        bus_write(5'h00, 32'h0);
        chk("R6", "pending after disable", 32'(irq_o), 32'h1);
        bus_write(5'h14, 32'h0);
        chk("R6", "pending after write 0", 32'(irq_o), 32'h1);
        bus_write(5'h14, 32'h1);
        chk("R6", "pending after write 1", 32'(irq_o), 32'h0);
        // R4/R8: timer 0 sweep
        for (int tc = 0; tc < 3; tc++)
            for (int pd = 0; pd < 3; pd++)
                sweep_tmr(0, tc, pd);
        // R7: disable mid-pulse
        bus_write(5'h00, 32'h0);
        bus_write(5'h14, 32'h1);
        bus_write(5'h04, 32'd3);
        bus_write(5'h0C, 32'd3);
        bus_write(5'h00, 32'h2);
        repeat (3) @(negedge clk);
        chk("R4", "pulse phase before freeze", 32'(tmr_out_o[1]), 32'h1);
        bus_write(5'h00, 32'h0);
        for (int k = 0; k < 10; k++) begin
            chk("R7", $sformatf("frozen out k=%0d", k), 32'(tmr_out_o[1]), 32'h0);
            chk("R7", $sformatf("frozen irq k=%0d", k), 32'(irq_o), 32'h0);
            @(negedge clk);
        end
        // R9: watchdog with N=5 and N=1
        for (int n = 1; n <= 5; n += 4) begin
            bus_write(5'h00, 32'h0);
            bus_write(5'h08, 32'((n << 8) | 8'hFF));
            bus_write(5'h00, 32'h1);
            for (int k = 0; k < n + 5; k++) begin
                chk("R9", $sformatf("wdog N=%0d k=%0d", n, k), 32'(wdog_rst_o), 32'(k == n));
                chk("R9", $sformatf("t0 out low N=%0d k=%0d", n, k), 32'(tmr_out_o[0]), 32'h0);
                @(negedge clk);
            end
        end
        // R10: kick postpones, and there is one pulse only
        bus_write(5'h00, 32'h0);
        bus_write(5'h08, 32'((6 << 8) | 8'hFF));
        bus_write(5'h00, 32'h1);
        for (int k = 0; k < 4; k++) begin
            chk("R10", $sformatf("before kick k=%0d", k), 32'(wdog_rst_o), 32'h0);
            @(negedge clk);
        end
        bus_write(5'h08, 32'((4 << 8) | 8'hFF));
        for (int k = 0; k < 12; k++) begin
            chk("R10", $sformatf("after kick k=%0d", k), 32'(wdog_rst_o), 32'(k == 4));
            chk("R8", $sformatf("irq in wdog mode k=%0d", k), 32'(irq_o), 32'h0);
            @(negedge clk);
        end
        bus_write(5'h00, 32'h0);
    endtask

    initial begin
        fork
            run_main();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule